// File: doc/BRIEF.md
# Iterative Integer Divide and Remainder Unit

This unit computes the quotient or the remainder of two integers for a core with 64-bit registers. It handles unsigned and signed operands, either at full 64-bit width or in a 32-bit mode. A one-cycle `start` strobe hands it the dividend, the divisor, a two-bit operation code and the width bit. It then holds `busy`, drives a registered 64-bit `result` and marks completion with a `done` pulse.

The unit never signals an exception. A zero divisor gives a fixed result that depends on the operation and the width. So does the one signed pair whose true quotient cannot be represented: the most-negative value divided by minus one. Both cases are recognised when the command arrives and finish on the next cycle. Every other pair goes through a radix-2 restoring loop on operand magnitudes that retires one quotient bit per clock. Signs are applied after the last step.

Top module: `divq_unit`

## Requirements
- R1: With `op` = 2'b00 (unsigned quotient) or 2'b10 (unsigned remainder) and `w32` = 0, `result` is the 64-bit unsigned quotient or remainder of `dividend` by a nonzero `divisor`.
- R2: With `op` = 2'b01 (signed quotient) or 2'b11 (signed remainder), the operands are two's complement. The quotient is truncated toward zero, and a nonzero remainder carries the sign of the dividend. Results wrap to the mode width and no flag is raised.
- R3: With `w32` = 1, only bits [31:0] of each operand are used, and every result has bits [63:32] cleared.
- R4: A quotient operation (`op[1]` = 0, signed or unsigned) whose divisor is zero in the active width returns 0 in both modes.
- R5: A remainder operation with a zero divisor and `w32` = 0 returns `dividend` unchanged.
- R6: A remainder operation with a zero divisor and `w32` = 1 returns `dividend[31:0]` zero-extended.
- R7: A signed quotient of the most-negative value by minus one returns 64'h8000_0000_0000_0000 when `w32` = 0, and 64'h0000_0000_8000_0000 when `w32` = 1.
- R8: A signed remainder of the most-negative value by minus one returns 0 in both modes.
- R9: The cases in R4 to R8 skip the iteration. `done` is high in the cycle right after the start cycle, and `busy` stays low.
- R10: Every other accepted command keeps `busy` high for 65 cycles (`w32` = 0) or 33 cycles (`w32` = 1). `done` then appears 66 or 34 cycles after the start cycle, and `busy` is never high together with `done`.
- R11: A `start` while `busy` is high is ignored. `result` stays unchanged from the `done` pulse until the next accepted `start`.
- R12: After a synchronous reset, `busy`, `done` and `result` are all zero.
- R13: `done` lasts one cycle per command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Command strobe, accepted when not busy |
| op | input | 2 | 00 unsigned quotient, 01 signed quotient, 10 unsigned remainder, 11 signed remainder |
| w32 | input | 1 | 1 selects the 32-bit mode |
| dividend | input | 64 | Dividend operand |
| divisor | input | 64 | Divisor operand |
| result | output | 64 | Registered result |
| busy | output | 1 | Iteration in progress |
| done | output | 1 | One-cycle completion strobe |

## Verification
The hardest case to reach from the ports is a strobe that arrives while the loop is running. Its operands are chosen to form a bypass pair, so if the strobe were wrongly accepted it would finish at once with a different value. The bench issues such a strobe partway through a 64-bit divide and then requires both the full latency and the original quotient. The 32-bit cases put nonzero data in the upper operand halves. A divisor that is zero only in its low half must trigger the zero-divisor path, and the upper half of the dividend must never leak into the result.

// File: rtl/divq_pkg.sv
package divq_pkg;

    localparam int XLEN = 64;
    localparam int HALF = XLEN / 2;
    localparam int CW   = $clog2(XLEN);

    typedef enum logic [1:0] {
        OP_UQUO = 2'b00,
        OP_SQUO = 2'b01,
        OP_UREM = 2'b10,
        OP_SREM = 2'b11
    } divq_op_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_FIX  = 2'd2
    } divq_state_e;

    typedef struct packed {
        logic [XLEN-1:0] mag_a;
        logic [XLEN-1:0] mag_b;
        logic            neg_q;
        logic            neg_r;
        logic            bypass;
        logic [XLEN-1:0] byp_val;
    } divq_prep_t;

    function automatic logic [XLEN-1:0] fit_width(input logic narrow, input logic [XLEN-1:0] v);
        return narrow ? {{HALF{1'b0}}, v[HALF-1:0]} : v;
    endfunction

    function automatic logic [XLEN-1:0] cond_neg(input logic neg, input logic [XLEN-1:0] v);
        return neg ? (~v + 1'b1) : v;
    endfunction

endpackage

// File: rtl/divq_prep.sv
module divq_prep
    import divq_pkg::*;
(
    input  divq_op_e         op,
    input  logic             w32,
    input  logic [XLEN-1:0]  a,
    input  logic [XLEN-1:0]  b,
    output divq_prep_t       p
);
    logic            sgn, sa, sb, b_zero, b_m1, a_min, ovf;
    logic [XLEN-1:0] a_ext, b_ext;

    always_comb begin
        sgn    = op[0];
        sa     = sgn & (w32 ? a[HALF-1] : a[XLEN-1]);
        sb     = sgn & (w32 ? b[HALF-1] : b[XLEN-1]);
        a_ext  = w32 ? {{HALF{sa}}, a[HALF-1:0]} : a;
        b_ext  = w32 ? {{HALF{sb}}, b[HALF-1:0]} : b;
        b_zero = w32 ? (b[HALF-1:0] == '0) : (b == '0);
        b_m1   = w32 ? (&b[HALF-1:0]) : (&b);
        a_min  = w32 ? (a[HALF-1:0] == {1'b1, {(HALF-1){1'b0}}})
                     : (a == {1'b1, {(XLEN-1){1'b0}}});
        ovf    = sgn & a_min & b_m1;

        p.mag_a  = cond_neg(sa, a_ext);
        p.mag_b  = cond_neg(sb, b_ext);
        p.neg_q  = sa ^ sb;
        p.neg_r  = sa;
        p.bypass = b_zero | ovf;
        if (b_zero)
            p.byp_val = op[1] ? fit_width(w32, a) : '0;
        else if (ovf)
            p.byp_val = op[1] ? '0 : fit_width(w32, a);
        else
            p.byp_val = '0;
    end
endmodule

// File: rtl/divq_core.sv
module divq_core #(
    parameter int W = 64
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic         step,
    input  logic         w32,
    input  logic [W-1:0] dvd,
    input  logic [W-1:0] dvs,
    output logic [W-1:0] quot,
    output logic [W-1:0] rem
);
    localparam int H = W / 2;

    logic [W:0]   rem_q;
    logic [W-1:0] quo_q, dvs_q;
    logic [W:0]   trial_rem, diff;
    logic         fits;

    always_comb begin
        trial_rem = {rem_q[W-1:0], quo_q[W-1]};
        diff      = trial_rem - {1'b0, dvs_q};
        fits      = (trial_rem >= {1'b0, dvs_q});
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rem_q <= '0;
            quo_q <= '0;
            dvs_q <= '0;
        end else if (load) begin
            rem_q <= '0;
            quo_q <= w32 ? {dvd[H-1:0], {H{1'b0}}} : dvd;
            dvs_q <= dvs;
        end else if (step) begin
            rem_q <= fits ? diff : trial_rem;
            quo_q <= {quo_q[W-2:0], fits};
        end
    end

    assign quot = quo_q;
    assign rem  = rem_q[W-1:0];

    // R1: restoring invariant, partial remainder stays below the divisor
    a_r1_partial_rem_bound: assert property (@(posedge clk) disable iff (rst)
        (dvs_q != '0) |-> (rem_q < {1'b0, dvs_q}));
endmodule

// File: rtl/divq_unit.sv
module divq_unit
    import divq_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [1:0]       op,
    input  logic             w32,
    input  logic [XLEN-1:0]  dividend,
    input  logic [XLEN-1:0]  divisor,
    output logic [XLEN-1:0]  result,
    output logic             busy,
    output logic             done
);
    divq_state_e     state;
    divq_prep_t      prep;
    logic [CW-1:0]   cnt;
    logic            neg_q_r, neg_r_r, is_rem_r, w32_r;
    logic            accept, core_load, core_step;
    logic [XLEN-1:0] quo, rem, pick;

    divq_prep u_prep (
        .op  (divq_op_e'(op)),
        .w32 (w32),
        .a   (dividend),
        .b   (divisor),
        .p   (prep)
    );

    assign accept    = start & (state == ST_IDLE);
    assign core_load = accept & ~prep.bypass;
    assign core_step = (state == ST_RUN);

    divq_core #(.W(XLEN)) u_core (
        .clk  (clk),
        .rst  (rst),
        .load (core_load),
        .step (core_step),
        .w32  (w32),
        .dvd  (prep.mag_a),
        .dvs  (prep.mag_b),
        .quot (quo),
        .rem  (rem)
    );

    assign pick = is_rem_r ? cond_neg(neg_r_r, rem) : cond_neg(neg_q_r, quo);

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            cnt      <= '0;
            result   <= '0;
            done     <= 1'b0;
            neg_q_r  <= 1'b0;
            neg_r_r  <= 1'b0;
            is_rem_r <= 1'b0;
            w32_r    <= 1'b0;
        end else begin
            done <= 1'b0;
            unique case (state)
                ST_IDLE: if (accept) begin
                    if (prep.bypass) begin
                        result <= prep.byp_val;
                        done   <= 1'b1;
                    end else begin
                        state    <= ST_RUN;
                        cnt      <= w32 ? CW'(HALF - 1) : CW'(XLEN - 1);
                        neg_q_r  <= prep.neg_q;
                        neg_r_r  <= prep.neg_r;
                        is_rem_r <= op[1];
                        w32_r    <= w32;
                    end
                end
                ST_RUN: begin
                    if (cnt == '0) state <= ST_FIX;
                    else           cnt   <= cnt - 1'b1;
                end
                ST_FIX: begin
                    result <= fit_width(w32_r, pick);
                    done   <= 1'b1;
                    state  <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign busy = (state != ST_IDLE);

    // R10: completion never overlaps an iteration in progress
    a_r10_busy_excludes_done: assert property (@(posedge clk) disable iff (rst)
        busy |-> !done);

    // R11: without an accepted command the result holds
    a_r11_result_hold: assert property (@(posedge clk) disable iff (rst)
        (!busy && !start) |=> $stable(result));

    // R4: quotient by zero gives zero on the next cycle
    a_r4_quo_by_zero: assert property (@(posedge clk) disable iff (rst)
        (start && !busy && !op[1] && (w32 ? divisor[HALF-1:0] == '0 : divisor == '0))
        |=> (done && result == '0));

    // R8: signed remainder of most-negative by minus one is zero
    a_r8_srem_ovf: assert property (@(posedge clk) disable iff (rst)
        (start && !busy && op == 2'b11 && !w32 && (&divisor)
         && dividend == {1'b1, {(XLEN-1){1'b0}}}) |=> (done && result == '0));

    // R9: bypassed commands never raise busy
    a_r9_bypass_fast: assert property (@(posedge clk) disable iff (rst)
        (start && !busy && (w32 ? divisor[HALF-1:0] == '0 : divisor == '0))
        |=> (!busy && done));
endmodule

// File: tb/divq_unit_tb.sv
`timescale 1ns/1ps
module divq_unit_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [1:0]  op = 2'b00;
    logic        w32 = 1'b0;
    logic [63:0] dividend = '0, divisor = '0;
    logic [63:0] result;
    logic        busy, done;

    int n_chk = 0, n_bad = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    divq_unit u_dut (
        .clk(clk), .rst(rst), .start(start), .op(op), .w32(w32),
        .dividend(dividend), .divisor(divisor),
        .result(result), .busy(busy), .done(done)
    );

    localparam int NV = 24;
    // {op, w32, dividend, divisor, expected}
    localparam logic [194:0] VEC [NV] = '{
        {2'b00, 1'b0, 64'd100, 64'd7, 64'd14},                                          // R1
        {2'b10, 1'b0, 64'd100, 64'd7, 64'd2},                                           // R1
        {2'b00, 1'b0, 64'hFFFF_FFFF_FFFF_FFFF, 64'd3, 64'h5555_5555_5555_5555},         // R1
        {2'b10, 1'b0, 64'hFFFF_FFFF_FFFF_FFFF, 64'h10, 64'hF},                          // R1
        {2'b01, 1'b0, 64'hFFFF_FFFF_FFFF_FFF9, 64'd2, 64'hFFFF_FFFF_FFFF_FFFD},         // R2
        {2'b11, 1'b0, 64'hFFFF_FFFF_FFFF_FFF9, 64'd2, 64'hFFFF_FFFF_FFFF_FFFF},         // R2
        {2'b11, 1'b0, 64'd7, 64'hFFFF_FFFF_FFFF_FFFE, 64'd1},                           // R2
        {2'b01, 1'b0, 64'hFFFF_FFFF_FFFF_FF9C, 64'hFFFF_FFFF_FFFF_FFF9, 64'd14},        // R2
        {2'b00, 1'b1, 64'hDEAD_BEEF_0000_0064, 64'hFFFF_FFFF_0000_0007, 64'd14},        // R3
        {2'b01, 1'b1, 64'h1234_5678_FFFF_FFF9, 64'd2, 64'h0000_0000_FFFF_FFFD},         // R3
        {2'b11, 1'b1, 64'h1234_5678_FFFF_FFF9, 64'd2, 64'h0000_0000_FFFF_FFFF},         // R3
        {2'b10, 1'b1, 64'hFFFF_FFFF_FFFF_FFFF, 64'h1_0000_0010, 64'hF},                 // R3
        {2'b00, 1'b0, 64'd123, 64'd0, 64'd0},                                           // R4
        {2'b01, 1'b1, 64'd5, 64'hFFFF_FFFF_0000_0000, 64'd0},                           // R4
        {2'b10, 1'b0, 64'hDEAD_BEEF_CAFE_F00D, 64'd0, 64'hDEAD_BEEF_CAFE_F00D},         // R5
        {2'b11, 1'b0, 64'h8000_0000_0000_0001, 64'd0, 64'h8000_0000_0000_0001},         // R5
        {2'b10, 1'b1, 64'hDEAD_BEEF_CAFE_F00D, 64'd0, 64'h0000_0000_CAFE_F00D},         // R6
        {2'b11, 1'b1, 64'hDEAD_BEEF_CAFE_F00D, 64'h7_0000_0000, 64'h0000_0000_CAFE_F00D}, // R6
        {2'b01, 1'b0, 64'h8000_0000_0000_0000, 64'hFFFF_FFFF_FFFF_FFFF, 64'h8000_0000_0000_0000}, // R7
        {2'b01, 1'b1, 64'hFFFF_FFFF_8000_0000, 64'h0000_0000_FFFF_FFFF, 64'h0000_0000_8000_0000}, // R7
        {2'b11, 1'b0, 64'h8000_0000_0000_0000, 64'hFFFF_FFFF_FFFF_FFFF, 64'd0},         // R8
        {2'b11, 1'b1, 64'h1_8000_0000, 64'h0000_0000_FFFF_FFFF, 64'd0},                 // R8
        {2'b00, 1'b0, 64'h8000_0000_0000_0000, 64'hFFFF_FFFF_FFFF_FFFF, 64'd0},         // R1
        {2'b01, 1'b0, 64'h8000_0000_0000_0000, 64'd2, 64'hC000_0000_0000_0000}          // R2
    };

    task automatic check(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Issues one command from a falling edge and returns result and latency in cycles.
    task automatic run_cmd(input logic [1:0] o, input logic w, input logic [63:0] a, input logic [63:0] b,
                           output logic [63:0] res, output int lat, output logic saw_busy);
        @(negedge clk);
        op = o; w32 = w; dividend = a; divisor = b; start = 1'b1;
        lat = 0; saw_busy = 1'b0;
        do begin
            @(posedge clk); @(negedge clk);
            start = 1'b0;
            lat++;
            if (busy) saw_busy = 1'b1;
        end while (!done && lat < 200);
        res = result;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual hung expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [63:0] res;
        int lat, exp_lat;
        logic sb, zero_b, ovf;
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;
        @(negedge clk);
        // R12: reset state
        check("R12", "busy", {63'd0, busy}, 64'd0);
        check("R12", "done", {63'd0, done}, 64'd0);
        check("R12", "result", result, 64'd0);

        for (int i = 0; i < NV; i++) begin
            logic [1:0] vo; logic vw; logic [63:0] va, vb, ve;
            {vo, vw, va, vb, ve} = VEC[i];
            zero_b = vw ? (vb[31:0] == 0) : (vb == 0);
            ovf = vo[0] && (vw ? (va[31:0] == 32'h8000_0000 && vb[31:0] == 32'hFFFF_FFFF)
                               : (va == 64'h8000_0000_0000_0000 && vb == '1));
            exp_lat = (zero_b || ovf) ? 1 : (vw ? 34 : 66);
            run_cmd(vo, vw, va, vb, res, lat, sb);
            check($sformatf("R1-R8 vector %0d", i), "result", res, ve);
            if (zero_b || ovf) begin
                check("R9", "bypass latency", 64'(lat), 64'(exp_lat));
                check("R9", "bypass busy", {63'd0, sb}, 64'd0);
            end else begin
                check("R10", "latency", 64'(lat), 64'(exp_lat));
            end
            @(posedge clk); @(negedge clk);
            check("R13", "done after pulse", {63'd0, done}, 64'd0);
        end

        // R11: start while busy is ignored
        @(negedge clk);
        op = 2'b00; w32 = 1'b0; dividend = 64'd1000; divisor = 64'd10; start = 1'b1;
        @(posedge clk); @(negedge clk); start = 1'b0;
        lat = 1;
        repeat (5) begin @(posedge clk); @(negedge clk); lat++; end
        op = 2'b01; dividend = 64'h8000_0000_0000_0000; divisor = '1; start = 1'b1;
        @(posedge clk); @(negedge clk); start = 1'b0; lat++;
        while (!done && lat < 200) begin @(posedge clk); @(negedge clk); lat++; end
        check("R11", "latency with ignored start", 64'(lat), 64'd66);
        check("R11", "result with ignored start", result, 64'd100);
        // R11: result holds with changing inputs and no start
        op = 2'b11; dividend = 64'h55; divisor = 64'd0;
        repeat (10) @(negedge clk);
        check("R11", "result hold", result, 64'd100);
        check("R13", "done stays low", {63'd0, done}, 64'd0);

        // R12: reset mid-iteration clears outputs
        @(negedge clk);
        op = 2'b00; w32 = 1'b0; dividend = 64'd77; divisor = 64'd3; start = 1'b1;
        @(negedge clk); start = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        check("R12", "busy after reset", {63'd0, busy}, 64'd0);
        check("R12", "result after reset", result, 64'd0);

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule